// File: doc/BRIEF.md
# Pipelined Doubling Iteration Counter

This block takes a pair of small unsigned operands, a 4-bit start value A and a 4-bit limit B. For each pair it counts how many times A can be doubled while it stays below B. The data-dependent loop is given a fixed bound of four guarded steps, which is enough for every legal pair. A is limited to 0..15 and B to 1..15.

The work runs in a chain of `STAGES` pipeline stages. Each stage keeps an item for `CYC_PER_STAGE` clock cycles. In each of those cycles it runs `4 / CYC_PER_STAGE` guarded doubling steps. A valid flag moves with the data, so the result shows up as a one-cycle strobe a fixed number of cycles after the pair was taken in.

The block has no back-pressure. A new pair is taken in only when the first stage is free, so the source spaces its pairs at least `CYC_PER_STAGE` cycles apart. `CYC_PER_STAGE` must be 1, 2 or 4.

Top module: `dbl_count_pipe`

## Requirements
- R1: For an accepted pair, `out_count` is a 3-bit binary number. It equals the number of times the guarded step (if value < B and steps < 4 then double the value and add one step) applies to the value A, starting from zero steps. It never exceeds 4.
- R2: `out_a` is a 5-bit unsigned value equal to A shifted left by `out_count`. When the count is nonzero this value is even.
- R3: A start value of 0 gives `out_count` = 4 and `out_a` = 0 for every limit 1..15.
- R4: A start value at or above the limit gives `out_count` = 0 and `out_a` equal to A.
- R5: `out_valid` is high for exactly one cycle per accepted pair. It comes exactly `STAGES*CYC_PER_STAGE` clock cycles after the cycle in which that pair's `in_valid` was high.
- R6: Pairs offered every `CYC_PER_STAGE` cycles or slower are all accepted. Their results come out in arrival order, and no stage overwrites an item still held by the next one.
- R7: An `in_valid` raised while the first stage is still busy (within `CYC_PER_STAGE-1` cycles after an accepted pair) is ignored. It produces no result and does not change the other pairs' results.
- R8: While reset is low, `out_valid` is low. Pairs inside the pipeline when reset is applied produce no result afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Offers the pair on `in_a`/`in_b` this cycle |
| in_a | input | 4 | Start value A, 0..15 |
| in_b | input | 4 | Limit B, 1..15 |
| out_valid | output | 1 | One-cycle strobe: result ready |
| out_count | output | 3 | Number of doublings, 0..4 |
| out_a | output | 5 | Final doubled value |

## Verification
The counting is tried on every legal pair of start value and limit. This shows the guard separates the limit from the step bound at each count from 0 to 4. The zero start value shows the bound saturating where the value condition never clears. Pairs that start at or above their limit show that no step is taken. The same results are also fed at the fastest rate, at irregular slower rates, with extra strobes while the first stage is busy, and with a reset in the middle of a run. These separate correct timing and hand-off between stages from lost, duplicated or stray results.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  // operand and result widths
  localparam int OPA_W      = 4;
  localparam int OPB_W      = 4;
  localparam int RES_W      = OPA_W + 1;
  // iteration bound found by interval analysis of the operand ranges
  localparam int LOOP_BOUND = 4;
  localparam int CNT_W      = $clog2(LOOP_BOUND + 1);

  typedef struct packed {
    logic [RES_W-1:0] val;    // value being doubled
    logic [OPB_W-1:0] lim;    // limit
    logic [CNT_W-1:0] steps;  // doublings so far
  } work_t;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q = chain_q[DEPTH-1];

endmodule

// File: rtl/dbl_step.sv
module dbl_step
  import dcp_pkg::*;
(
  input  work_t din,
  output work_t dout
);

  logic below_lim;
  logic below_bnd;

  always_comb begin
    below_lim = din.val < RES_W'(din.lim);
    below_bnd = din.steps < CNT_W'(LOOP_BOUND);
    dout      = din;
    if (below_lim && below_bnd) begin
      dout.val   = din.val << 1;
      dout.steps = din.steps + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dbl_slice.sv
module dbl_slice
  import dcp_pkg::*;
#(
  parameter int ITERS = 2
) (
  input  work_t src,
  output work_t dst
);

  work_t chain [ITERS+1];

  assign chain[0] = src;

  for (genvar g = 0; g < ITERS; g++) begin : g_iter
    dbl_step u_step (
      .din  (chain[g]),
      .dout (chain[g+1])
    );
  end

  assign dst = chain[ITERS];

endmodule

// File: rtl/pipe_stage.sv
module pipe_stage
  import dcp_pkg::*;
#(
  parameter int CYC = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  up_done,
  input  work_t up_item,
  output logic  done,
  output logic  idle,
  output work_t item
);

  localparam int ITERS = LOOP_BOUND / CYC;
  localparam int CYC_W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CYC_W-1:0] RELOAD = CYC_W'(CYC - 1);

  logic             vld_q, vld_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             item_en;
  work_t            item_q;
  work_t            src;
  work_t            stepped;

  assign idle = (cyc_q == '0);

  // next state: an idle stage loads from upstream, a busy one continues its own item
  always_comb begin
    vld_d   = vld_q;
    cyc_d   = cyc_q;
    item_en = 1'b0;
    src     = item_q;
    if (idle) begin
      src     = up_item;
      vld_d   = up_done;
      cyc_d   = up_done ? RELOAD : '0;
      item_en = up_done;
    end else begin
      cyc_d   = cyc_q - CYC_W'(1);
      item_en = 1'b1;
    end
  end

  dbl_slice #(.ITERS(ITERS)) u_slice (
    .src (src),
    .dst (stepped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cyc_q <= '0;
    end else begin
      vld_q <= vld_d;
      cyc_q <= cyc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (item_en) begin
      item_q <= stepped;
    end
  end

  assign done = vld_q && idle;
  assign item = item_q;

endmodule

// File: rtl/dbl_count_pipe.sv
module dbl_count_pipe
  import dcp_pkg::*;
#(
  parameter int STAGES        = 3,
  parameter int CYC_PER_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OPA_W-1:0] in_a,
  input  logic [OPB_W-1:0] in_b,
  output logic             out_valid,
  output logic [CNT_W-1:0] out_count,
  output logic [RES_W-1:0] out_a
);

  logic              rst_q;
  logic [STAGES-1:0] st_done;
  logic [STAGES-1:0] st_idle;
  work_t             st_item [STAGES];
  work_t             in_item;
  logic              in_accept;

  rst_sync #(.DEPTH(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  always_comb begin
    in_item.val   = RES_W'(in_a);
    in_item.lim   = in_b;
    in_item.steps = '0;
  end

  assign in_accept = in_valid && st_idle[0];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic  up_done;
    work_t up_item;
    if (g == 0) begin : g_head
      assign up_done = in_valid;
      assign up_item = in_item;
    end else begin : g_body
      assign up_done = st_done[g-1];
      assign up_item = st_item[g-1];
    end
    pipe_stage #(.CYC(CYC_PER_STAGE)) u_stage (
      .clk     (clk),
      .rst_n   (rst_q),
      .up_done (up_done),
      .up_item (up_item),
      .done    (st_done[g]),
      .idle    (st_idle[g]),
      .item    (st_item[g])
    );
  end

  assign out_valid = st_done[STAGES-1];
  assign out_count = st_item[STAGES-1].steps;
  assign out_a     = st_item[STAGES-1].val;

endmodule

// File: rtl/dcp_checker.sv
module dcp_checker
  import dcp_pkg::*;
#(
  parameter int STAGES        = 3,
  parameter int CYC_PER_STAGE = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_accept,
  input logic             out_valid,
  input logic [CNT_W-1:0] out_count,
  input logic [RES_W-1:0] out_a,
  input logic [STAGES-1:0] st_done,
  input logic [STAGES-1:0] st_idle
);

  localparam int LAT = STAGES * CYC_PER_STAGE;

  // accept history: bit LAT-1 marks a result due now
  logic [LAT-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= (hist_q << 1) | LAT'(in_accept);
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_count <= CNT_W'(LOOP_BOUND));

  p_even_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_count != '0) |-> (out_a[0] == 1'b0));

  p_zero_saturates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_a == '0) |-> (out_count == CNT_W'(LOOP_BOUND)));

  p_no_early_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> hist_q[LAT-1]);

  p_no_late_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hist_q[LAT-1] |-> out_valid);

  for (genvar g = 1; g < STAGES; g++) begin : g_handoff
    p_handoff_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st_done[g-1] |-> st_idle[g]);
  end

endmodule

bind dbl_count_pipe dcp_checker #(
  .STAGES        (STAGES),
  .CYC_PER_STAGE (CYC_PER_STAGE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .in_accept (in_accept),
  .out_valid (out_valid),
  .out_count (out_count),
  .out_a     (out_a),
  .st_done   (st_done),
  .st_idle   (st_idle)
);

// File: tb/sim_dbl_count_pipe.sv
module sim_dbl_count_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 3;
  localparam int CYC        = 2;
  localparam int LAT        = STAGES * CYC;
  localparam int QD         = 512;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] in_a;
  logic [3:0] in_b;
  logic       out_valid;
  logic [2:0] out_count;
  logic [4:0] out_a;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc_cnt  = 0;
  bit finished = 0;

  int    exp_cnt [QD];
  int    exp_val [QD];
  int    exp_t   [QD];
  string exp_tag [QD];
  int    wr_ptr = 0;
  int    rd_ptr = 0;

  dbl_count_pipe #(.STAGES(STAGES), .CYC_PER_STAGE(CYC)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_count (out_count),
    .out_a     (out_a)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference: the guarded doubling written straight from R1/R2
  function automatic void model(input int a, input int b, output int c, output int v);
    c = 0;
    v = a;
    while (v < b && c < 4) begin
      v = v * 2;
      c = c + 1;
    end
  endfunction

  // output monitor, samples away from the rising edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd_ptr == wr_ptr) begin
        check(1'b0, "R7", "unexpected out_valid", 1, 0);
      end else begin
        check(out_count == exp_cnt[rd_ptr % QD], exp_tag[rd_ptr % QD], "count",
              int'(out_count), exp_cnt[rd_ptr % QD]);
        check(out_a == exp_val[rd_ptr % QD], exp_tag[rd_ptr % QD], "value",
              int'(out_a), exp_val[rd_ptr % QD]);
        check(cyc_cnt - exp_t[rd_ptr % QD] == LAT, "R5", "latency",
              cyc_cnt - exp_t[rd_ptr % QD], LAT);
        rd_ptr++;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // offer one pair for one cycle and record what must come out
  task automatic send(input int a, input int b, input string tag);
    int c, v;
    model(a, b, c, v);
    in_a     = 4'(a);
    in_b     = 4'(b);
    in_valid = 1'b1;
    exp_cnt[wr_ptr % QD] = c;
    exp_val[wr_ptr % QD] = v;
    exp_t[wr_ptr % QD]   = cyc_cnt;
    exp_tag[wr_ptr % QD] = tag;
    wr_ptr++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    idle(LAT + CYC + 3);
    check(rd_ptr == wr_ptr, tag, "results outstanding", wr_ptr - rd_ptr, 0);
  endtask

  task automatic t_reset;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_a     = '0;
    in_b     = 4'd1;
    idle(3);
    check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    idle(4);
    check(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_basic;
    send(1, 15, "R1"); idle(CYC - 1);
    send(3, 7,  "R1"); idle(CYC - 1);
    send(5, 6,  "R2"); idle(CYC - 1);
    send(7, 15, "R2"); idle(CYC - 1);
    send(1, 9,  "R1"); idle(CYC - 1);
    drain("R1");
  endtask

  task automatic t_zero;
    int c, v;
    model(0, 15, c, v);
    check(c == 4 && v == 0, "R3", "model for zero start", c, 4);
    send(0, 1,  "R3"); idle(CYC - 1);
    send(0, 15, "R3"); idle(CYC - 1);
    send(0, 8,  "R3"); idle(CYC - 1);
    drain("R3");
  endtask

  task automatic t_no_loop;
    send(15, 15, "R4"); idle(CYC - 1);
    send(9, 3,   "R4"); idle(CYC - 1);
    send(1, 1,   "R4"); idle(CYC - 1);
    drain("R4");
  endtask

  task automatic t_sweep;
    for (int a = 0; a < 16; a++) begin
      for (int b = 1; b < 16; b++) begin
        send(a, b, "R1");
        idle(CYC - 1);
      end
    end
    drain("R6");
  endtask

  task automatic t_spacing;
    send(2, 11, "R6"); idle(CYC);
    send(4, 13, "R6"); idle(CYC + 2);
    send(1, 3,  "R6"); idle(CYC - 1);
    send(6, 7,  "R6"); idle(CYC + 1);
    send(3, 14, "R6");
    drain("R6");
  endtask

  task automatic t_busy_ignore;
    if (CYC > 1) begin
      send(1, 12, "R7");
      for (int i = 0; i < CYC - 1; i++) begin
        in_a     = 4'd0;
        in_b     = 4'd15;
        in_valid = 1'b1;
        @(negedge clk);
      end
      in_valid = 1'b0;
      send(5, 9, "R7");
      drain("R7");
    end
  endtask

  task automatic t_reset_mid;
    send(1, 15, "R8"); idle(CYC - 1);
    send(2, 15, "R8");
    idle(1);
    rst_n = 1'b0;
    idle(2);
    check(out_valid == 1'b0, "R8", "out_valid in mid reset", int'(out_valid), 0);
    rd_ptr = wr_ptr;
    rst_n  = 1'b1;
    idle(LAT + 6);
    check(rd_ptr == wr_ptr, "R8", "results after reset", rd_ptr - wr_ptr, 0);
    send(3, 13, "R8");
    drain("R8");
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_zero();
    t_no_loop();
    t_spacing();
    t_busy_ignore();
    t_sweep();
    t_reset_mid();
    finished = 1;
    report();
  end

endmodule